// File: doc/BRIEF.md
# Parking Two-Resource Arbiter with Crossing Abort

This block holds two independent arbitration engines for shared board resources. The first gives the local processor sites exclusive use of a bidirectional FIFO. The second guards a combined resource: a shared RAM, the outbound system-bus master path and the board control registers. That resource can be requested by every local site and by one external system-bus master. Each requester raises a level request, waits for its grant, and keeps the request high for the whole of its cycle. Dropping the request marks the cycle as done.

The grant is never returned to idle. It stays parked on the last owner, so a parked owner that requests again is granted in the same cycle. Arbitration runs only when a requester other than the owner asks for the resource while the owner is not in a cycle. It takes `ARB_LAT` clock cycles and picks the winner round-robin, starting with the requester after the current owner.

A local site can hold the combined resource for an outbound system-bus cycle. If an external inbound access arrives during that cycle, the two would block each other. The block breaks this deadlock by pulsing a bus error to the external master and refusing it the grant until it withdraws that request.

Top module: `shared_res_arbiter`

## Requirements
- R1: After reset both arbiters are parked on site A (index 0), and every grant and the bus error are low. A lone request from site A is then granted in the same cycle on either arbiter.
- R2: Each arbiter grants at most one requester at a time, and the two arbiters are independent. One site may hold the FIFO while another site, or the external master, holds the combined resource.
- R3: When the parked owner requests while no other requester is pending, its grant rises in the same cycle, without arbitration.
- R4: A request from a non-owner, made while the owner is not in a cycle, is granted on the second rising edge after it is presented (`ARB_LAT`=2). The grant is low until then.
- R5: A contested arbitration picks the first requester in ascending index order after the current owner, wrapping around. The owner has the lowest priority. Indices are site A=0 and site B=1, and on the combined arbiter the external master is 2.
- R6: While the owner keeps its request high after being granted, the grant does not move, whatever other requests appear.
- R7: When the external master requests while a site holds the combined resource with its outbound flag high, `ext_berr` is high for exactly one cycle. That cycle is the first one in which the request is seen.
- R8: An aborted external request is not granted for as long as it stays high, even after the site finishes. Once the request is withdrawn and raised again, it arbitrates normally.
- R9: An external request that meets a site owner whose own outbound flag is low raises no bus error. It waits and wins once the site releases. Another site's outbound flag has no effect.
- R10: The winner is fixed when arbitration starts. If the winner withdraws before its grant, the grant stays parked on it, and its next lone request is granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_req | input | NUM_SITES | FIFO requests, one per site, held through the cycle |
| fifo_gnt | output | NUM_SITES | FIFO grants |
| ram_req | input | NUM_SITES+1 | Combined-resource requests; top bit is the external master |
| ram_outbound | input | NUM_SITES | Per-site flag: the site's combined-resource cycle is an outbound bus-master cycle |
| ram_gnt | output | NUM_SITES+1 | Combined-resource grants |
| ext_berr | output | 1 | One-cycle bus-error pulse to the external master |

## Verification
Both arbiters are swept over every parked owner and every non-empty request mask. A single-bit mask equal to the owner separates the same-cycle parked path from arbitration. The other masks separate the round-robin order from a fixed priority and check the two-cycle latency and the hold while the owner is busy. Directed sequences place the external request against a site owner with the outbound flag set and then cleared. These separate a real crossing from an ordinary wait, confirm that the pulse is a single cycle and that the refusal lasts until the request is withdrawn. A winner that withdraws during arbitration checks that the grant parks on the winner rather than reverting.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {ST_PARK, ST_ARB} arb_st_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N = 2,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] cur,
   output logic [IW-1:0] win
);
   // first requester after cur, wrapping; cur itself is searched last
   always_comb begin
      int   idx;
      logic found;
      win   = cur;
      found = 1'b0;
      for (int k = 1; k <= N; k++) begin
         idx = int'(cur) + k;
         if (idx >= N) idx = idx - N;
         if (req[idx] && !found) begin
            win   = IW'(idx);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/park_arb.sv
module park_arb
   import arb_pkg::*;
#(
   parameter int N           = 2,
   parameter int ARB_LAT     = 2,
   parameter int RESET_OWNER = 0,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] owner_o,
   output logic          locked_o
);
   localparam int CW = (ARB_LAT > 2) ? $clog2(ARB_LAT - 1) : 1;

   if (N < 2) begin : g_bad_n
      $error("park_arb: N must be at least 2");
   end
   if (ARB_LAT < 1) begin : g_bad_lat
      $error("park_arb: ARB_LAT must be at least 1");
   end
   if (RESET_OWNER >= N) begin : g_bad_owner
      $error("park_arb: RESET_OWNER out of range");
   end

   arb_st_e       st;
   logic [IW-1:0] owner, win, pick;
   logic          locked, won;
   logic [N-1:0]  own_mask;
   logic          others, own_go, start, arb_end;

   assign own_mask = {{(N-1){1'b0}}, 1'b1} << owner;
   assign others   = |(req & ~own_mask);
   assign own_go   = rst_n && (st == ST_PARK) && req[owner] && (locked || won || !others);
   assign start    = (st == ST_PARK) && !own_go && others;
   assign gnt      = own_go ? own_mask : '0;
   assign owner_o  = owner;
   assign locked_o = locked;

   rr_pick #(.N(N)) u_pick (.req(req), .cur(owner), .win(pick));

   if (ARB_LAT > 1) begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)                          cnt <= '0;
         else if (start)                      cnt <= CW'(ARB_LAT - 2);
         else if (st == ST_ARB && cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign arb_end = (st == ST_ARB) && (cnt == '0);
   end else begin : g_direct
      assign arb_end = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_PARK;
         owner  <= IW'(RESET_OWNER);
         win    <= IW'(RESET_OWNER);
         locked <= 1'b0;
         won    <= 1'b0;
      end else begin
         locked <= own_go;
         won    <= 1'b0;
         case (st)
            ST_PARK: begin
               if (start) begin
                  win <= pick;
                  if (ARB_LAT == 1) begin
                     owner <= pick;
                     won   <= 1'b1;
                  end else begin
                     st <= ST_ARB;
                  end
               end
            end
            ST_ARB: begin
               if (arb_end) begin
                  owner <= win;
                  won   <= 1'b1;
                  st    <= ST_PARK;
               end
            end
            default: st <= ST_PARK;
         endcase
      end
   end

   // R2: one grant at most
   assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R6: a grant that is still requested does not move
   assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt) |=> (((req & $past(gnt)) == '0) || (gnt == $past(gnt))));
   // R3: with nothing requested the parked owner stays put
   assert_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PARK && !(|req)) |=> $stable(owner));
   if (ARB_LAT > 1) begin : g_lat_chk
      // R4: ownership only moves at the end of an arbitration
      assert_move_after_arb_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(owner) |-> ($past(st) == ST_ARB));
   end
endmodule

// File: rtl/xing_guard.sv
module xing_guard #(
   parameter int NS = 2,
   localparam int IW = $clog2(NS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ext_req,
   input  logic [IW-1:0] owner,
   input  logic          locked,
   input  logic [NS-1:0] outbound,
   output logic          ext_pass,
   output logic          berr
);
   logic [NS:0] ob_ext;
   logic        conflict, abort;

   // the external slot carries no outbound flag
   assign ob_ext   = {1'b0, outbound};
   assign conflict = ext_req && locked && ob_ext[owner];
   assign berr     = conflict && !abort;
   assign ext_pass = ext_req && !conflict && !abort;

   always_ff @(posedge clk) begin
      if (!rst_n)        abort <= 1'b0;
      else if (!ext_req) abort <= 1'b0;
      else if (conflict) abort <= 1'b1;
   end

   // R7: the error pulse lasts one cycle
   assert_berr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      berr |=> !berr);
   // R8: an aborted access stays blocked while still requested
   assert_abort_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (berr && ext_req) |=> (!ext_pass || !$past(ext_req)));
endmodule

// File: rtl/shared_res_arbiter.sv
module shared_res_arbiter #(
   parameter int NUM_SITES = 2,
   parameter int ARB_LAT   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SITES-1:0] fifo_req,
   output logic [NUM_SITES-1:0] fifo_gnt,
   input  logic [NUM_SITES:0]   ram_req,
   input  logic [NUM_SITES-1:0] ram_outbound,
   output logic [NUM_SITES:0]   ram_gnt,
   output logic                 ext_berr
);
   localparam int FW  = $clog2(NUM_SITES);
   localparam int RW  = $clog2(NUM_SITES + 1);
   localparam int EXT = NUM_SITES;

   if (NUM_SITES < 2) begin : g_bad_sites
      $error("shared_res_arbiter: NUM_SITES must be at least 2");
   end

   logic [FW-1:0]      fifo_owner;
   logic               fifo_locked;
   logic [RW-1:0]      ram_owner;
   logic               ram_locked;
   logic               ext_pass;
   logic [NUM_SITES:0] ram_req_eff;

   park_arb #(.N(NUM_SITES), .ARB_LAT(ARB_LAT), .RESET_OWNER(0)) u_fifo_arb (
      .clk(clk), .rst_n(rst_n), .req(fifo_req), .gnt(fifo_gnt),
      .owner_o(fifo_owner), .locked_o(fifo_locked));

   xing_guard #(.NS(NUM_SITES)) u_guard (
      .clk(clk), .rst_n(rst_n), .ext_req(ram_req[EXT]), .owner(ram_owner),
      .locked(ram_locked), .outbound(ram_outbound), .ext_pass(ext_pass),
      .berr(ext_berr));

   assign ram_req_eff = {ext_pass, ram_req[NUM_SITES-1:0]};

   park_arb #(.N(NUM_SITES + 1), .ARB_LAT(ARB_LAT), .RESET_OWNER(0)) u_ram_arb (
      .clk(clk), .rst_n(rst_n), .req(ram_req_eff), .gnt(ram_gnt),
      .owner_o(ram_owner), .locked_o(ram_locked));

   // R7: the aborted master is never granted in the error cycle
   assert_no_grant_on_berr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_berr |-> !ram_gnt[EXT]);
   // R8: nor in the cycle after
   assert_no_grant_after_berr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_berr |=> !ram_gnt[EXT]);
   // R6: a FIFO owner in its cycle keeps the grant
   assert_fifo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_locked && fifo_req[fifo_owner]) |-> fifo_gnt[fifo_owner]);
endmodule

// File: tb/shared_res_arbiter_test.sv
module shared_res_arbiter_test;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] fifo_req = '0;
   logic [NS-1:0] fifo_gnt;
   logic [NS:0]   ram_req = '0;
   logic [NS-1:0] ram_outbound = '0;
   logic [NS:0]   ram_gnt;
   logic          ext_berr;

   int nchk = 0;
   int nerr = 0;
   int fifo_own = 0;
   int ram_own = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shared_res_arbiter #(.NUM_SITES(NS), .ARB_LAT(2)) uut (
      .clk(clk), .rst_n(rst_n), .fifo_req(fifo_req), .fifo_gnt(fifo_gnt),
      .ram_req(ram_req), .ram_outbound(ram_outbound), .ram_gnt(ram_gnt),
      .ext_berr(ext_berr));

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int rr(input int n, input int o, input int m);
      for (int k = 1; k <= n; k++) begin
         int i;
         i = (o + k) % n;
         if (m[i]) return i;
      end
      return o;
   endfunction

   task automatic set_req(input int n, input int v);
      if (n == NS) fifo_req = v[NS-1:0];
      else         ram_req  = v[NS:0];
   endtask

   function automatic int get_gnt(input int n);
      if (n == NS) return int'(fifo_gnt);
      return int'(ram_gnt);
   endfunction

   task automatic park(input int n, input int o);
      int cur;
      cur = (n == NS) ? fifo_own : ram_own;
      if (cur != o) begin
         set_req(n, 1 << o);
         tick(); tick();
         set_req(n, 0);
         tick();
         if (n == NS) fifo_own = o; else ram_own = o;
      end
   endtask

   // every parked owner against every non-empty request mask
   task automatic sweep(input int n);
      for (int o = 0; o < n; o++) begin
         for (int m = 1; m < (1 << n); m++) begin
            int w;
            park(n, o);
            set_req(n, m);
            #1;
            if (m == (1 << o)) begin
               chk("R3 parked owner same-cycle grant", get_gnt(n), m);
            end else begin
               w = rr(n, o, m);
               chk("R4 no grant in decision cycle", get_gnt(n), 0);
               tick();
               chk("R4 no grant after first edge", get_gnt(n), 0);
               tick();
               chk("R5 round-robin winner after owner", get_gnt(n), 1 << w);
               if (n == NS) fifo_own = w; else ram_own = w;
               tick(); tick();
               chk("R6 grant held while owner busy", get_gnt(n), 1 << w);
            end
            chk("R9 no bus error without outbound", int'(ext_berr), 0);
            set_req(n, 0);
            tick();
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      tick(); tick();
      chk("R1 fifo grant low in reset", int'(fifo_gnt), 0);
      chk("R1 ram grant low in reset", int'(ram_gnt), 0);
      chk("R1 berr low in reset", int'(ext_berr), 0);
      rst_n = 1'b1;
      tick();
      chk("R1 fifo grant low after reset", int'(fifo_gnt), 0);
      chk("R1 berr low after reset", int'(ext_berr), 0);
      fifo_req = 2'b01; ram_req = 3'b001;
      #1;
      chk("R1 fifo parked on site A", int'(fifo_gnt), 1);
      chk("R1 ram parked on site A", int'(ram_gnt), 1);
      fifo_req = '0; ram_req = '0;
      tick();

      // R2 concurrency across arbiters
      fifo_req = 2'b10; ram_req = 3'b001;
      #1;
      chk("R2 ram site A granted", int'(ram_gnt), 1);
      tick(); tick();
      chk("R2 fifo site B alongside ram site A", int'(fifo_gnt), 2);
      chk("R2 ram site A still held", int'(ram_gnt), 1);
      ram_req = 3'b100;
      tick(); tick();
      chk("R2 ram external while fifo site B", int'(ram_gnt), 4);
      chk("R2 fifo site B unaffected", int'(fifo_gnt), 2);
      fifo_req = '0; ram_req = '0;
      fifo_own = 1; ram_own = 2;
      tick();

      sweep(NS);
      sweep(NS + 1);

      // R7 / R8 crossing
      park(NS + 1, 0);
      ram_outbound = 2'b01; ram_req = 3'b001;
      #1;
      chk("R7 site A outbound granted", int'(ram_gnt), 1);
      tick();
      ram_req = 3'b101;
      #1;
      chk("R7 bus error on crossing", int'(ext_berr), 1);
      chk("R7 site A keeps grant", int'(ram_gnt), 1);
      tick();
      chk("R7 bus error single cycle", int'(ext_berr), 0);
      chk("R7 site A finishes", int'(ram_gnt), 1);
      ram_req = 3'b100; ram_outbound = '0;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R8 aborted access not granted", int'(ram_gnt), 0);
         chk("R8 no repeated bus error", int'(ext_berr), 0);
      end
      ram_req = '0;
      tick();
      ram_req = 3'b100;
      #1;
      chk("R8 retry raises no error", int'(ext_berr), 0);
      tick(); tick();
      chk("R8 retry granted after arbitration", int'(ram_gnt), 4);
      ram_own = 2;
      ram_req = '0;
      tick();

      // R9 ordinary wait, other site's flag irrelevant
      ram_outbound = 2'b01; ram_req = 3'b010;
      tick(); tick();
      chk("R9 site B granted", int'(ram_gnt), 2);
      tick();
      ram_req = 3'b110;
      #1;
      chk("R9 no error with owner flag low", int'(ext_berr), 0);
      tick(); tick();
      chk("R9 site B holds", int'(ram_gnt), 2);
      chk("R9 still no error", int'(ext_berr), 0);
      ram_req = 3'b100;
      #1;
      chk("R9 external waits in decision cycle", int'(ram_gnt), 0);
      tick(); tick();
      chk("R9 external granted after release", int'(ram_gnt), 4);
      ram_own = 2;
      ram_req = '0; ram_outbound = '0;
      tick();

      // R10 withdrawn winner stays parked
      ram_req = 3'b001;
      tick();
      ram_req = '0;
      tick();
      chk("R10 withdrawn winner not granted", int'(ram_gnt), 0);
      tick();
      ram_req = 3'b001;
      #1;
      chk("R10 parked on withdrawn winner", int'(ram_gnt), 1);
      ram_req = '0;
      tick();

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule